// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches a group of asynchronous port pins and flags a change interrupt when any pin selected by a per-pin enable register no longer matches the level captured at the most recent software access to the port. The pins first pass through a synchronizer. Every port read or write strobe refreshes a snapshot register from the synchronized levels, and the comparison is always made against that snapshot. It is never made against the previous clock edge. The block therefore keeps flagging until software touches the port.

The flag is sticky. Software clears it by writing 0, and that clear only takes effect once the mismatch has been removed by a port access. A wake request, for an external sleep controller, combines the flag with the live gated mismatch. Power-on reset and the other reset causes (external pin reset, brown-out) come in on separate inputs, and they affect the state differently.

Top module: `pinchg_watch`

## Requirements
- R1: Each pin level reaches `port_rd` after `SYNC_STAGES` rising clock edges (default 2). It takes no earlier edge.
- R2: A cycle with `en_wr` high loads `en_wdata` into the per-pin enable register. Power-on reset (`por_n` low) clears every enable bit.
- R3: If an enabled pin's synchronized level differs from its snapshot bit in a cycle with no port access, `chg_flag` is 1 after the next edge. A mismatch on a disabled pin has no effect on `chg_flag` or `wake_req`.
- R4: A cycle with `port_acc` high loads the snapshot from the synchronized levels. This ends the mismatch from the next cycle on.
- R5: `chg_flag` holds its value until it is written. A write with `flag_wr` high and `flag_wdata`=0 clears it when no set is pending. When a set is pending in the same cycle, the set wins. A write of 1 sets the flag.
- R6: A low level on `rst_n` (external or brown-out reset) clears `chg_flag` and keeps both the snapshot and the enable register. Once `rst_n` returns high, a mismatch that is still present sets the flag again after one edge.
- R7: Power-on reset clears `chg_flag` and loads the snapshot from the current synchronized pin levels.
- R8: `wake_req` is the OR of `chg_flag` and the enabled mismatch. It is combinational, so it rises in the same cycle that the changed level appears on `port_rd`.
- R9: If the first mismatch cycle coincides with a port access, the change is missed. The flag stays 0 and the mismatch ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | External or brown-out reset, active low, synchronous |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | NPINS | Enable register write data |
| port_acc | input | 1 | Software port read or write strobe |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value |
| port_rd | output | NPINS | Synchronized pin levels |
| chg_flag | output | 1 | Sticky change interrupt flag |
| wake_req | output | 1 | Wake request to the sleep controller |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software clear of the flag and a pending set. The bench provokes it by writing 0 while an enabled pin still differs from its snapshot, and it passes only if the flag stays 1. The second is a port access and the first cycle of a new mismatch. The bench raises `port_acc` in exactly the cycle where the new level first shows on `port_rd`, and it passes only if the flag never rises and `wake_req` drops on the next cycle.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
    localparam int unsigned PINS_DEFAULT = 6;
    localparam int unsigned SYNC_DEFAULT = 2;

    function automatic logic any_diff(input logic [31:0] en,
                                      input logic [31:0] a,
                                      input logic [31:0] b);
        return |(en & (a ^ b));
    endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
    parameter int unsigned NPINS       = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic [NPINS-1:0] raw_i,
    output logic [NPINS-1:0] lvl_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [SYNC_STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[SYNC_STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk) begin
            sh_q <= sh_d;
        end

        assign lvl_o[g] = sh_q[LAST];
    end
endmodule

// File: rtl/pinchg_state.sv
module pinchg_state #(
    parameter int unsigned NPINS = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_wdata,
    input  logic             port_acc,
    input  logic [NPINS-1:0] lvl_i,
    output logic [NPINS-1:0] en_o,
    output logic [NPINS-1:0] snap_o
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] snap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr)    st_d.en   = en_wdata;
        if (port_acc) st_d.snap = lvl_i;
        if (!por_n) begin
            st_d.en   = '0;
            st_d.snap = lvl_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign snap_o = st_q.snap;

    // R2
    por_clears_en_chk: assert property (@(posedge clk) !por_n |=> (en_o == '0));

    // R4
    acc_loads_snap_chk: assert property (@(posedge clk) disable iff (!por_n)
        port_acc |=> (snap_o == $past(lvl_i)));

    // R4
    snap_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        !port_acc |=> $stable(snap_o));
endmodule

// File: rtl/pinchg_flag.sv
module pinchg_flag (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = set_i | (wr_i ? wdata_i : flag_q);
        if (!por_n || !rst_n) flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        set_i |=> flag_o);

    // R5
    clear_works_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_i && !wdata_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pinchg_watch.sv
module pinchg_watch #(
    parameter int unsigned NPINS       = pinchg_pkg::PINS_DEFAULT,
    parameter int unsigned SYNC_STAGES = pinchg_pkg::SYNC_DEFAULT
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_wdata,
    input  logic             port_acc,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic [NPINS-1:0] port_rd,
    output logic             chg_flag,
    output logic             wake_req
);
    logic [NPINS-1:0] lvl, en_q, snap_q;
    logic             mism, set_req;

    pinchg_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .raw_i (pin_i),
        .lvl_o (lvl)
    );

    pinchg_state #(.NPINS(NPINS)) state_i (
        .clk      (clk),
        .por_n    (por_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .port_acc (port_acc),
        .lvl_i    (lvl),
        .en_o     (en_q),
        .snap_o   (snap_q)
    );

    always_comb begin
        mism    = pinchg_pkg::any_diff(32'(en_q), 32'(lvl), 32'(snap_q));
        set_req = mism & ~port_acc;
    end

    pinchg_flag flag_i (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .set_i   (set_req),
        .wr_i    (flag_wr),
        .wdata_i (flag_wdata),
        .flag_o  (chg_flag)
    );

    assign port_rd  = lvl;
    assign wake_req = chg_flag | mism;

    // R9
    acc_no_new_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (port_acc && !chg_flag && !(flag_wr && flag_wdata)) |=> !chg_flag);
endmodule

// File: tb/pinchg_watch_tb_top.sv
`timescale 1ns/1ps
module pinchg_watch_tb_top;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          por_n, rst_n, en_wr, port_acc, flag_wr, flag_wdata;
    logic [NP-1:0] pin_i, en_wdata, port_rd;
    logic          chg_flag, wake_req;
    int            checks = 0;
    int            errors = 0;

    always #10 clk = ~clk;

    pinchg_watch #(.NPINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .pin_i(pin_i),
        .en_wr(en_wr), .en_wdata(en_wdata), .port_acc(port_acc),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .port_rd(port_rd), .chg_flag(chg_flag), .wake_req(wake_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        por_n = 0; rst_n = 1; pin_i = '0; en_wr = 0; en_wdata = '0;
        port_acc = 0; flag_wr = 0; flag_wdata = 0;
        repeat (5) tick();
        por_n = 1;
        tick();
        chk("R7 flag after por", chg_flag, 0);
        chk("R8 wake after por", wake_req, 0);
        chk("R1 levels after por", port_rd, 0);
    endtask

    task automatic t_enable_set();
        en_wr = 1; en_wdata = 6'b000001; tick(); en_wr = 0;
        pin_i = 6'b000001;
        tick();
        chk("R1 not after one edge", port_rd, 0);
        tick();
        chk("R1 after two edges", port_rd, 6'b000001);
        chk("R8 wake same cycle", wake_req, 1);
        chk("R3 flag not yet", chg_flag, 0);
        tick();
        chk("R3 flag set", chg_flag, 1);
    endtask

    task automatic t_clear_vs_set();
        flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
        chk("R5 set beats clear", chg_flag, 1);
    endtask

    task automatic t_access_clear();
        port_acc = 1; tick(); port_acc = 0;
        chk("R4 flag held over access", chg_flag, 1);
        flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
        chk("R5 clear after access", chg_flag, 0);
        chk("R4 mismatch ended", wake_req, 0);
    endtask

    task automatic t_disabled_pin();
        pin_i = 6'b000011;
        repeat (3) tick();
        chk("R3 disabled pin flag", chg_flag, 0);
        chk("R3 disabled pin wake", wake_req, 0);
    endtask

    task automatic t_write_one();
        flag_wr = 1; flag_wdata = 1; tick(); flag_wr = 0;
        chk("R5 write one", chg_flag, 1);
        flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
        chk("R5 write zero", chg_flag, 0);
    endtask

    task automatic t_ext_reset();
        pin_i = 6'b000010;
        repeat (3) tick();
        chk("R3 flag before ext reset", chg_flag, 1);
        rst_n = 0; tick();
        chk("R6 flag cleared", chg_flag, 0);
        tick();
        chk("R6 enables and snapshot kept", wake_req, 1);
        rst_n = 1; tick();
        chk("R6 flag sets again", chg_flag, 1);
        port_acc = 1; tick(); port_acc = 0;
        flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
        chk("R6 cleared after access", chg_flag, 0);
    endtask

    task automatic t_same_cycle();
        pin_i = 6'b000011;
        tick(); tick();
        chk("R9 mismatch visible", wake_req, 1);
        port_acc = 1; tick(); port_acc = 0;
        chk("R9 change missed flag", chg_flag, 0);
        chk("R9 change missed wake", wake_req, 0);
        tick();
        chk("R9 flag stays clear", chg_flag, 0);
    endtask

    task automatic t_por();
        pin_i = 6'b000010;
        repeat (3) tick();
        chk("R3 flag before por", chg_flag, 1);
        por_n = 0; tick(); por_n = 1; tick();
        chk("R7 flag cleared by por", chg_flag, 0);
        chk("R2 enables cleared", wake_req, 0);
        en_wr = 1; en_wdata = 6'b000001; tick(); en_wr = 0;
        chk("R7 snapshot from levels", wake_req, 0);
        pin_i = 6'b000011;
        tick(); tick();
        chk("R2 enable reloaded", wake_req, 1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_enable_set();
        t_clear_vs_set();
        t_access_clear();
        t_disabled_pin();
        t_write_one();
        t_ext_reset();
        t_same_cycle();
        t_por();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule